// File: doc/BRIEF.md
# Multi-packet framing splitter

This block sits in a wide receive path after lane deskew. The path runs at half the symbol rate. Each core clock it takes one 256-bit word: 16 lanes, each carrying two consecutive 8-bit symbols. No control symbols mark where packets begin or end. Each packet opens with a four-symbol start token. The token holds a marker nibble and a length in doublewords, and that length is the only thing that says where the packet stops. The splitter scans the word doubleword by doubleword, follows the lengths across word boundaries, and hands packets to the layer above as a valid/ready stream. Each output beat carries at most one packet.

Packets as short as 20 bytes are allowed. So one word can hold the tail of one packet together with one or two new start tokens. The input register works as the serializing buffer. It keeps the word and releases one segment per cycle, oldest first, and it holds the upstream ready low until the word's last segment has been taken. No packet is ever discarded. A doubleword outside a packet that is neither all zero nor a well-formed start token raises a one-cycle framing-error pulse, and the scan carries on from the next doubleword.

Top module: `frameSplit`

## Requirements
- R1: During and right after reset, `outValid` and `errPulse` are 0 and `inReady` is 1.
- R2: Symbol k (0..31) of a word is the low byte of lane k when k < 16, and the high byte of lane k-16 otherwise. Lane L occupies `inData[16L+15:16L]`. `outData[8k+7:8k]` carries symbol k of the word the beat comes from.
- R3: A start token is only looked for at doubleword slot j (symbols 4j..4j+3) outside a packet. A slot is a token when the upper nibble of symbol 4j is 0xF. Its length is {symbol 4j bits 2:0, symbol 4j+1} in doublewords and counts the token itself. The packet covers that many consecutive slots, beginning with the token slot.
- R4: Each beat sets `outKeep[4j+3:4j]` to all ones for every slot j of the packet present in that word, and to zero for every other slot. `outStart` marks the beat holding the token. `outEnd` marks the beat holding the last doubleword.
- R5: The remaining length carries across words. A packet longer than the rest of its word continues from slot 0 of the following words.
- R6: When one word holds pieces of two or three packets, each piece goes out as its own beat, in slot order. The next word is not taken until the last piece is accepted.
- R7: While `outValid` is 1 and `outReady` is 0, `outData`, `outKeep`, `outStart` and `outEnd` stay unchanged and `outValid` stays 1. No packet is lost.
- R8: All-zero doublewords outside a packet are idle. They produce no beat and no error.
- R9: A non-zero doubleword outside a packet that is not a start token raises `errPulse` for one cycle. It produces no beat, and the scan resumes at the next slot.
- R10: A token whose length is below 5 raises `errPulse` for one cycle. No packet is started from it.
- R11: After reset and after every end beat, the next beat is a start beat. No start beat appears before the current packet's end beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input word present |
| inReady | output | 1 | Input word accepted on this edge when valid |
| inData | input | 256 | 16 lanes of two symbols each, lane-major |
| outValid | output | 1 | Output beat present |
| outReady | input | 1 | Layer above takes the beat |
| outData | output | 256 | Word in symbol order |
| outKeep | output | 32 | Byte enables of the packet's symbols in this beat |
| outStart | output | 1 | Beat holds the start token |
| outEnd | output | 1 | Beat holds the packet's last doubleword |
| errPulse | output | 1 | Framing error seen this cycle |

## Verification
Some properties are checked on every cycle by assertions: a stalled beat stays frozen, start and end beats alternate, an error cycle carries no beat, and a packet in progress always has doublewords left. Other behaviour only shows up through the bench's sweeps. This covers whether lengths are decoded correctly, whether packet boundaries land on the right slots across word edges, whether pieces come out in order when two starts share a word, and whether every packet comes out exactly once. For this, packet lengths from 5 to 24 are swept against gaps of 0 to 3 idle doublewords. Then random mixes with bad doublewords, short tokens and a long packet are run under random backpressure. The expected beats are derived from each packet's slot positions.

// File: rtl/frameSplitPkg.sv
package frameSplitPkg;
  localparam int SYM_W = 8;
  localparam int DW_SYMS = 4;

  // strobes from the scan control to the word datapath
  typedef struct packed {
    logic loadWord;
  } dpStrobeT;
endpackage

// File: rtl/frameSplitData.sv
module frameSplitData
  import frameSplitPkg::*;
#(
  parameter int LANES = 16,
  parameter int SPL = 2,
  parameter int LEN_W = 11,
  parameter logic [3:0] MARKER = 4'hF,
  localparam int NSYM = LANES * SPL,
  localparam int W = NSYM * SYM_W,
  localparam int NDW = NSYM / DW_SYMS
) (
  input  logic clk,
  input  logic rstN,
  input  dpStrobeT strobe,
  input  logic [W-1:0] inData,
  input  logic [NDW-1:0] segMask,
  output logic [W-1:0] outData,
  output logic [NSYM-1:0] outKeep,
  output logic [NDW-1:0] slotZero,
  output logic [NDW-1:0] slotTok,
  output logic [NDW-1:0][LEN_W-1:0] slotLen
);
  logic [W-1:0] holdWord;
  logic [W-1:0] symWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) holdWord <= '0;
    else if (strobe.loadWord) holdWord <= inData;
  end

  // lane-major input to symbol-time-major order
  for (genvar k = 0; k < NSYM; k++) begin : g_sym
    localparam int LANE = k % LANES;
    localparam int TIME = k / LANES;
    assign symWord[k*SYM_W +: SYM_W] = holdWord[(LANE*SPL + TIME)*SYM_W +: SYM_W];
  end

  for (genvar j = 0; j < NDW; j++) begin : g_slot
    localparam int B = j * DW_SYMS * SYM_W;
    assign slotZero[j] = (symWord[B +: DW_SYMS*SYM_W] == '0);
    assign slotTok[j]  = (symWord[B+4 +: 4] == MARKER);
    assign slotLen[j]  = {symWord[B +: LEN_W-SYM_W], symWord[B+SYM_W +: SYM_W]};
    assign outKeep[j*DW_SYMS +: DW_SYMS] = {DW_SYMS{segMask[j]}};
  end

  assign outData = symWord;
endmodule

// File: rtl/frameSplitCtrl.sv
module frameSplitCtrl
  import frameSplitPkg::*;
#(
  parameter int NDW = 8,
  parameter int LEN_W = 11,
  parameter int MIN_LEN = 5,
  localparam int PW = $clog2(NDW + 1),
  localparam int CW = LEN_W + 1
) (
  input  logic clk,
  input  logic rstN,
  input  logic inValid,
  output logic inReady,
  input  logic outReady,
  input  logic [NDW-1:0] slotZero,
  input  logic [NDW-1:0] slotTok,
  input  logic [NDW-1:0][LEN_W-1:0] slotLen,
  output dpStrobeT strobe,
  output logic [NDW-1:0] segMask,
  output logic outValid,
  output logic outStart,
  output logic outEnd,
  output logic errPulse
);
  logic holdValid, inPkt;
  logic [PW-1:0] ptr, nextPtr, segLo, firstIdx;
  logic [LEN_W-1:0] rem, nextRem;
  logic [CW-1:0] len, room, cnt;
  logic seg, isStart, isEnd, err, firstFound, restIdle, nextInPkt;
  logic advance, done, load;

  always_comb begin
    firstFound = 1'b0;
    firstIdx = '0;
    for (int j = NDW - 1; j >= 0; j--) begin
      if (j >= int'(ptr) && !slotZero[j]) begin
        firstFound = 1'b1;
        firstIdx = PW'(j);
      end
    end
    seg = 1'b0; isStart = 1'b0; isEnd = 1'b0; err = 1'b0;
    segLo = ptr; len = {1'b0, rem}; cnt = '0;
    nextPtr = ptr; nextRem = rem; nextInPkt = inPkt;
    if (inPkt) begin
      seg = 1'b1;
    end else if (firstFound) begin
      if (slotTok[firstIdx] && slotLen[firstIdx] >= LEN_W'(MIN_LEN)) begin
        seg = 1'b1;
        isStart = 1'b1;
        segLo = firstIdx;
        len = {1'b0, slotLen[firstIdx]};
      end else begin
        err = 1'b1;
        nextPtr = firstIdx + PW'(1);
      end
    end else begin
      nextPtr = PW'(NDW);
    end
    room = CW'(NDW) - CW'(segLo);
    if (seg) begin
      isEnd = (len <= room);
      cnt = isEnd ? len : room;
      nextPtr = segLo + PW'(cnt);
      nextRem = LEN_W'(len - cnt);
      nextInPkt = !isEnd;
    end
    for (int j = 0; j < NDW; j++)
      segMask[j] = seg && (j >= int'(segLo)) && (j < int'(segLo) + int'(cnt));
    restIdle = 1'b1;
    for (int j = 0; j < NDW; j++)
      if (j >= int'(nextPtr) && !slotZero[j]) restIdle = 1'b0;
  end

  assign advance = holdValid && (!seg || outReady);
  assign done = advance && (nextPtr == PW'(NDW) || (restIdle && !nextInPkt));
  assign inReady = !holdValid || done;
  assign load = inValid && inReady;
  assign strobe.loadWord = load;
  assign outValid = holdValid && seg;
  assign outStart = isStart;
  assign outEnd = isEnd;
  assign errPulse = holdValid && err;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdValid <= 1'b0;
      ptr <= '0;
      inPkt <= 1'b0;
      rem <= '0;
    end else begin
      if (advance) begin
        ptr <= nextPtr;
        inPkt <= nextInPkt;
        rem <= nextRem;
      end
      if (load) begin
        holdValid <= 1'b1;
        ptr <= '0;
      end else if (done) begin
        holdValid <= 1'b0;
      end
    end
  end

  // expected framing of the next beat, for the alternation check
  logic expStartQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) expStartQ <= 1'b1;
    else if (outValid && outReady) expStartQ <= outEnd;
  end

  // R11
  start_end_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outStart == expStartQ));
  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(segMask) && $stable(outStart) && $stable(outEnd));
  // R9
  err_no_beat_chk: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> !outValid);
  // R4
  keep_nonempty_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> segMask != '0);
  // R5
  pkt_rem_chk: assert property (@(posedge clk) disable iff (!rstN)
    inPkt |-> rem != '0);
endmodule

// File: rtl/frameSplit.sv
module frameSplit
  import frameSplitPkg::*;
#(
  parameter int LANES = 16,
  parameter int SYM_PER_LANE = 2,
  parameter int LEN_W = 11,
  parameter logic [3:0] MARKER = 4'hF,
  parameter int MIN_LEN = 5,
  localparam int NSYM = LANES * SYM_PER_LANE,
  localparam int W = NSYM * SYM_W,
  localparam int NDW = NSYM / DW_SYMS
) (
  input  logic clk,
  input  logic rstN,
  input  logic inValid,
  output logic inReady,
  input  logic [W-1:0] inData,
  output logic outValid,
  input  logic outReady,
  output logic [W-1:0] outData,
  output logic [NSYM-1:0] outKeep,
  output logic outStart,
  output logic outEnd,
  output logic errPulse
);
  dpStrobeT strobe;
  logic [NDW-1:0] segMask, slotZero, slotTok;
  logic [NDW-1:0][LEN_W-1:0] slotLen;

  frameSplitData #(.LANES(LANES), .SPL(SYM_PER_LANE), .LEN_W(LEN_W), .MARKER(MARKER)) i_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inData(inData), .segMask(segMask),
    .outData(outData), .outKeep(outKeep), .slotZero(slotZero), .slotTok(slotTok),
    .slotLen(slotLen)
  );

  frameSplitCtrl #(.NDW(NDW), .LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) i_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .outReady(outReady),
    .slotZero(slotZero), .slotTok(slotTok), .slotLen(slotLen), .strobe(strobe),
    .segMask(segMask), .outValid(outValid), .outStart(outStart), .outEnd(outEnd),
    .errPulse(errPulse)
  );

  // R7
  stall_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> $stable(outData) && $stable(outKeep));
endmodule

// File: tb/test_frameSplit.sv
module test_frameSplit;
  localparam int MAXDW = 4096;
  localparam int MAXW = 512;
  localparam int MAXEXP = 2048;

  logic clk = 1'b0, rstN = 1'b0, inValid = 1'b0, outReady = 1'b1;
  logic [255:0] inData = '0;
  logic inReady, outValid, outStart, outEnd, errPulse;
  logic [255:0] outData;
  logic [31:0] outKeep;

  frameSplit i_frameSplit (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inData(inData),
    .outValid(outValid), .outReady(outReady), .outData(outData), .outKeep(outKeep),
    .outStart(outStart), .outEnd(outEnd), .errPulse(errPulse)
  );

  always #5 clk = ~clk;

  int checks = 0, failures = 0;
  logic [31:0] dwVal[MAXDW];
  int dwPid[MAXDW];
  bit dwFirst[MAXDW], dwLast[MAXDW];
  int nDw = 0, pidNext = 0, expErr = 0;
  logic [255:0] wordsSym[MAXW];
  logic [31:0] expKeep[MAXEXP];
  bit expStart[MAXEXP], expEnd[MAXEXP];
  int expWord[MAXEXP];
  int nExp = 0, recvIdx = 0, errSeen = 0;
  bit readyMode = 0, benchStart = 1, monOn = 0;
  logic [15:0] lfsr = 16'hACE1, genLfsr = 16'h3C5A;
  logic pValid = 0, pReady = 0, pStart = 0, pEnd = 0;
  logic [255:0] pData = '0;
  logic [31:0] pKeep = '0;

  function automatic logic [255:0] toLanes(logic [255:0] s);
    logic [255:0] r;
    for (int k = 0; k < 32; k++) r[((k % 16) * 2 + k / 16) * 8 +: 8] = s[k*8 +: 8];
    return r;
  endfunction

  task automatic addDw(logic [31:0] v, int pid, bit f, bit l);
    dwVal[nDw] = v; dwPid[nDw] = pid; dwFirst[nDw] = f; dwLast[nDw] = l; nDw++;
  endtask

  // R3 token layout: symbol0 = {F, 0, len[10:8]}, symbol1 = len[7:0]
  task automatic addPkt(int len);
    logic [10:0] l11 = 11'(len);
    addDw({8'hA5, 8'(pidNext), l11[7:0], 5'b11110, l11[10:8]}, pidNext, 1, len == 1);
    for (int i = 1; i < len; i++)
      addDw({8'(pidNext), 8'(i), 8'(i >> 8), 8'h5A}, pidNext, 0, i == len - 1);
    pidNext++;
  endtask

  task automatic addIdle(int n);
    for (int i = 0; i < n; i++) addDw(32'h0, -1, 0, 0);
  endtask

  task automatic addBad();
    addDw(32'h0000_00C3, -1, 0, 0); expErr++;
  endtask

  task automatic addShort(int len);
    addDw({16'h0, 8'(len), 8'hF0}, -1, 0, 0); expErr++;
  endtask

  always @(negedge clk) begin
    if (monOn) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      outReady = readyMode ? (lfsr[0] | lfsr[3]) : 1'b1;
      #1;
      if (pValid && !pReady) begin
        checks++;
        if (!(outValid && outData == pData && outKeep == pKeep && outStart == pStart && outEnd == pEnd)) begin
          failures++;
          $display("FAIL R7 stalled beat changed: valid=%0b keep=%h start=%0b end=%0b expected keep=%h start=%0b end=%0b",
                   outValid, outKeep, outStart, outEnd, pKeep, pStart, pEnd);
        end
      end
      if (errPulse) errSeen++;
      if (outValid && outReady) begin
        checks++;
        if (recvIdx >= nExp) begin
          failures++;
          $display("FAIL R6 extra beat: got index %0d expected count %0d", recvIdx, nExp);
        end else begin
          if (outKeep != expKeep[recvIdx] || outStart != expStart[recvIdx] || outEnd != expEnd[recvIdx]) begin
            failures++;
            $display("FAIL R4 beat %0d: keep=%h start=%0b end=%0b expected keep=%h start=%0b end=%0b",
                     recvIdx, outKeep, outStart, outEnd, expKeep[recvIdx], expStart[recvIdx], expEnd[recvIdx]);
          end
          if (outData != wordsSym[expWord[recvIdx]]) begin
            failures++;
            $display("FAIL R2 beat %0d data=%h expected %h", recvIdx, outData, wordsSym[expWord[recvIdx]]);
          end
        end
        // R11 start follows end
        checks++;
        if (outStart != benchStart) begin
          failures++;
          $display("FAIL R11 start flag=%0b expected %0b", outStart, benchStart);
        end
        benchStart = outEnd;
        recvIdx++;
      end
      pValid = outValid; pReady = outReady; pData = outData; pKeep = outKeep;
      pStart = outStart; pEnd = outEnd;
    end
  end

  task automatic runStream(string tag);
    int nW, cur;
    while (nDw % 8 != 0) addIdle(1);
    nW = nDw / 8;
    nExp = 0;
    for (int w = 0; w < nW; w++) begin
      for (int j = 0; j < 8; j++) wordsSym[w][32*j +: 32] = dwVal[8*w + j];
      cur = -1;
      for (int j = 0; j < 8; j++) begin
        int i = 8*w + j;
        if (dwPid[i] < 0) begin cur = -1; continue; end
        if (dwPid[i] != cur) begin
          nExp++;
          expKeep[nExp-1] = '0; expStart[nExp-1] = dwFirst[i]; expWord[nExp-1] = w;
          cur = dwPid[i];
        end
        expKeep[nExp-1] |= 32'hF << (4*j);
        expEnd[nExp-1] = dwLast[i];
      end
    end
    recvIdx = 0; errSeen = 0;
    for (int w = 0; w < nW; w++) begin
      @(negedge clk); inValid = 1'b1; inData = toLanes(wordsSym[w]);
      #2;
      while (!inReady) begin @(negedge clk); #2; end
    end
    @(negedge clk); inValid = 1'b0;
    for (int t = 0; t < 4000 && recvIdx < nExp; t++) @(negedge clk);
    repeat (20) @(negedge clk);
    checks++;
    if (recvIdx != nExp) begin
      failures++;
      $display("FAIL R6 %s beats=%0d expected %0d", tag, recvIdx, nExp);
    end
    checks++;
    if (errSeen != expErr) begin
      failures++;
      $display("FAIL R9/R10 %s error pulses=%0d expected %0d", tag, errSeen, expErr);
    end
    nDw = 0; expErr = 0;
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    checks++;
    if (outValid !== 1'b0 || errPulse !== 1'b0 || inReady !== 1'b1) begin
      failures++;
      $display("FAIL R1 in reset valid=%b err=%b ready=%b expected 0 0 1", outValid, errPulse, inReady);
    end
    @(negedge clk); rstN = 1'b1;
    #1;
    checks++;
    if (outValid !== 1'b0 || errPulse !== 1'b0 || inReady !== 1'b1) begin
      failures++;
      $display("FAIL R1 after reset valid=%b err=%b ready=%b expected 0 0 1", outValid, errPulse, inReady);
    end
    monOn = 1;

    // R3 R5 R6 R8: length x gap sweep, two starts per word at small lengths
    for (int len = 5; len <= 24; len++) begin
      for (int gap = 0; gap <= 3; gap++) begin
        addIdle(gap);
        for (int p = 0; p < 3; p++) begin addPkt(len); addIdle(gap); end
      end
      readyMode = (len % 2 == 1);
      runStream($sformatf("sweep len %0d", len));
    end

    readyMode = 1;
    // R9 R6: random mix with bad doublewords
    for (int i = 0; i < 40; i++) begin
      genLfsr = {genLfsr[14:0], genLfsr[15] ^ genLfsr[13] ^ genLfsr[12] ^ genLfsr[10]};
      addPkt(5 + int'(genLfsr[7:0]) % 56);
      addIdle(int'(genLfsr[9:8]) % 3);
      if (genLfsr[12:10] == 3'd0) addBad();
    end
    runStream("random mix");

    // R10: short tokens, lengths 0 through 4
    for (int l = 0; l < 5; l++) begin addShort(l); addPkt(5 + l); end
    runStream("short tokens");

    // R5: long packet across many words, odd slot start
    addIdle(3); addPkt(300); addPkt(5); addPkt(5);
    runStream("long packet");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule